// File: doc/BRIEF.md
# Matched Core/Memory Clock Divider Pair

This block divides two unrelated clocks so that the results run at the same frequency and can be handed to an external phase comparator. One divider runs on the core clock and divides by M. The other runs on the memory interface clock and divides by N. The pair (M, N) is picked so that core frequency / M equals memory frequency / N. For example, a 133 MHz core and a 100 MHz memory clock with M = 4 and N = 3 both give about 33 MHz. The gear ratio is core frequency / memory frequency, and it equals M/N.

A new pair, together with an enable bit, is loaded through a valid/ready port in the core domain. A transfer happens on a core clock rising edge that sees both `cfg_valid_i` and `cfg_ready_o` high. The sender must hold `cfg_valid_i` and the fields until that edge. After each transfer, `cfg_ready_o` stays low while the N value crosses into the memory domain through a toggle handshake. Any `cfg_valid_i` seen during that time is not taken.

The block checks the accepted pair and reports the result on `cfg_ok_o`. A pair that fails the check, or a disabled pair, parks both outputs low. Each output's rising edge marks the wrap of its own counter, so the two rising edges are the ones to compare. A new divisor is only taken at a wrap, so a change never produces a shortened pulse.

Top module: `gear_div_pair`

## Requirements
- R1: While reset is applied and after it is released with no configuration loaded, both divided outputs are low, `cfg_ok_o` is low and `cfg_ready_o` is high.
- R2: `cfg_ok_o` is low after a transfer in which M or N is zero.
- R3: `cfg_ok_o` is high only if M/N is one of the supported ratios: 1 (M = N), 2 (M = 2N), 4/3 (3M = 4N) or 3/2 (2M = 3N).
- R4: `cfg_ok_o` is high only if both divided periods lie within [MIN_PS, MAX_PS]. The core period is M * CORE_PS and the memory period is N * MEM_PS. The defaults are 7500 ps, 10000 ps, 30000 ps and 100000 ps.
- R5: With a valid, enabled pair, `core_div_o` repeats every M core cycles. It goes high on the cycle its counter wraps to zero and stays high for floor(M/2) cycles, or for 1 cycle when M = 1.
- R6: With a valid, enabled pair, `mem_div_o` repeats every N memory cycles and stays high for floor(N/2) cycles, or for 1 cycle when N = 1.
- R7: When the accepted pair is disabled (`cfg_en_i` = 0) or fails the check, each output finishes its current period and then stays low.
- R8: A new divisor takes effect only at a counter wrap. Every high pulse therefore has the full length for either the old divisor or the new one.
- R9: `cfg_ready_o` falls on the edge after a transfer and rises again only once the memory domain has captured the new N. A `cfg_valid_i` asserted while `cfg_ready_o` is low changes nothing.
- R10: `cfg_ok_o` changes only on the edge after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Active-low asynchronous reset, core domain |
| mem_clk | input | 1 | Memory interface clock |
| mem_rst_n | input | 1 | Active-low asynchronous reset, memory domain |
| cfg_valid_i | input | 1 | A configuration is offered |
| cfg_ready_o | output | 1 | A configuration can be taken |
| cfg_m_i | input | DIV_W | Core divisor M |
| cfg_n_i | input | DIV_W | Memory divisor N |
| cfg_en_i | input | 1 | Enable the divided outputs |
| cfg_ok_o | output | 1 | The last accepted pair passed the check |
| core_div_o | output | 1 | Core clock divided by M |
| mem_div_o | output | 1 | Memory clock divided by N |

## Verification
The bench walks legal pairs of every supported ratio, including odd divisors where the high time is shorter than the low time. It also walks pairs that fail on a zero divisor, on an unsupported ratio or on the period window. A design that rounds the odd high time up would show a wrong high count. A design that checks only the ratio would drive 15 ns outputs for a (2, 2) pair. The bench switches divisors and then disables while a divider is running, and it measures every high pulse. A design that reloads without waiting for a wrap would emit a runt pulse. The bench also offers a configuration while the crossing is still in flight. A design that accepted it would corrupt N in the memory domain or change `cfg_ok_o`.

// File: rtl/gdp_pkg.sv
`timescale 1ns/1ps
package gdp_pkg;

  // Supported gear ratios M/N: 1, 2, 4/3, 3/2
  function automatic logic gdp_ratio_ok(input logic [31:0] m, input logic [31:0] n);
    return (m == n) || (m == 2 * n) || (3 * m == 4 * n) || (2 * m == 3 * n);
  endfunction

  // Period in picoseconds lies in the allowed window
  function automatic logic gdp_period_ok(input logic [31:0] div, input logic [31:0] clk_ps,
                                         input logic [31:0] lo_ps, input logic [31:0] hi_ps);
    logic [31:0] p;
    p = div * clk_ps;
    return (p >= lo_ps) && (p <= hi_ps);
  endfunction

endpackage

// File: rtl/gdp_sync.sv
`timescale 1ns/1ps
module gdp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gdp_cfg_ctrl.sv
`timescale 1ns/1ps
module gdp_cfg_ctrl
  import gdp_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int CORE_PS = 7500,
  parameter int MEM_PS  = 10000,
  parameter int MIN_PS  = 30000,
  parameter int MAX_PS  = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [DIV_W-1:0] m_i,
  input  logic [DIV_W-1:0] n_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic             ready_o,
  output logic             ok_o,
  output logic             run_o,
  output logic [DIV_W-1:0] m_o,
  output logic [DIV_W-1:0] n_o,
  output logic             req_o
);
  logic [31:0] m_w, n_w;
  logic        pair_ok;
  logic        take;
  logic        ok_q, en_q, req_q;
  logic [DIV_W-1:0] m_q, n_q;

  assign m_w = 32'(m_i);
  assign n_w = 32'(n_i);

  always_comb begin
    pair_ok = (m_i != '0) && (n_i != '0)
           && gdp_ratio_ok(m_w, n_w)
           && gdp_period_ok(m_w, 32'(CORE_PS), 32'(MIN_PS), 32'(MAX_PS))
           && gdp_period_ok(n_w, 32'(MEM_PS),  32'(MIN_PS), 32'(MAX_PS));
  end

  // Ready while no crossing is in flight
  assign ready_o = (ack_i == req_q);
  assign take    = valid_i && ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      en_q  <= 1'b0;
      req_q <= 1'b0;
      m_q   <= '0;
      n_q   <= '0;
    end else if (take) begin
      ok_q  <= pair_ok;
      en_q  <= en_i;
      m_q   <= m_i;
      n_q   <= n_i;
      req_q <= ~req_q;
    end
  end

  assign ok_o  = ok_q;
  assign run_o = ok_q && en_q;
  assign m_o   = m_q;
  assign n_o   = n_q;
  assign req_o = req_q;
endmodule

// File: rtl/gdp_mem_capture.sv
`timescale 1ns/1ps
module gdp_mem_capture #(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [DIV_W-1:0] n_i,
  input  logic             run_i,
  output logic [DIV_W-1:0] n_o,
  output logic             run_o,
  output logic             ack_o
);
  logic req_s;
  logic ack_q, run_q;
  logic [DIV_W-1:0] n_q;

  gdp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(req_s)
  );

  // Bus from the core side is held still while the toggles differ
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      run_q <= 1'b0;
      n_q   <= '0;
    end else if (req_s != ack_q) begin
      n_q   <= n_i;
      run_q <= run_i;
      ack_q <= req_s;
    end
  end

  assign n_o   = n_q;
  assign run_o = run_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/gdp_divider.sv
`timescale 1ns/1ps
module gdp_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             out_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             active_q, out_q;
  logic [DIV_W-1:0] cnt_q, div_q, hi_q;
  logic [DIV_W-1:0] cnt_inc;
  logic             wrap, start;

  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] d);
    return (d == ONE) ? ONE : (d >> 1);
  endfunction

  assign cnt_inc = cnt_q + ONE;
  assign wrap    = (cnt_q == div_q - ONE);
  assign start   = run_i && (div_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      out_q    <= 1'b0;
      cnt_q    <= '0;
      div_q    <= '0;
      hi_q     <= '0;
    end else if (!active_q || wrap) begin
      cnt_q <= '0;
      if (start) begin
        active_q <= 1'b1;
        div_q    <= div_i;
        hi_q     <= high_len(div_i);
        out_q    <= 1'b1;
      end else begin
        active_q <= 1'b0;
        out_q    <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_inc;
      out_q <= (cnt_inc < hi_q);
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/gear_div_pair.sv
`timescale 1ns/1ps
module gear_div_pair #(
  parameter int DIV_W       = 4,
  parameter int CORE_PS     = 7500,
  parameter int MEM_PS      = 10000,
  parameter int MIN_PS      = 30000,
  parameter int MAX_PS      = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             core_clk,
  input  logic             core_rst_n,
  input  logic             mem_clk,
  input  logic             mem_rst_n,
  input  logic             cfg_valid_i,
  output logic             cfg_ready_o,
  input  logic [DIV_W-1:0] cfg_m_i,
  input  logic [DIV_W-1:0] cfg_n_i,
  input  logic             cfg_en_i,
  output logic             cfg_ok_o,
  output logic             core_div_o,
  output logic             mem_div_o
);
  logic             core_run, mem_run;
  logic [DIV_W-1:0] core_m, core_n, mem_n;
  logic             req_tog, ack_tog, ack_sync;

  gdp_cfg_ctrl #(
    .DIV_W(DIV_W), .CORE_PS(CORE_PS), .MEM_PS(MEM_PS),
    .MIN_PS(MIN_PS), .MAX_PS(MAX_PS)
  ) u_ctrl (
    .clk(core_clk), .rst_n(core_rst_n),
    .valid_i(cfg_valid_i), .m_i(cfg_m_i), .n_i(cfg_n_i), .en_i(cfg_en_i),
    .ack_i(ack_sync), .ready_o(cfg_ready_o), .ok_o(cfg_ok_o),
    .run_o(core_run), .m_o(core_m), .n_o(core_n), .req_o(req_tog)
  );

  gdp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(core_clk), .rst_n(core_rst_n), .d_i(ack_tog), .q_o(ack_sync)
  );

  gdp_mem_capture #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(mem_clk), .rst_n(mem_rst_n), .req_i(req_tog),
    .n_i(core_n), .run_i(core_run),
    .n_o(mem_n), .run_o(mem_run), .ack_o(ack_tog)
  );

  gdp_divider #(.DIV_W(DIV_W)) u_core_div (
    .clk(core_clk), .rst_n(core_rst_n), .run_i(core_run),
    .div_i(core_m), .out_o(core_div_o)
  );

  gdp_divider #(.DIV_W(DIV_W)) u_mem_div (
    .clk(mem_clk), .rst_n(mem_rst_n), .run_i(mem_run),
    .div_i(mem_n), .out_o(mem_div_o)
  );
endmodule

// File: rtl/gear_div_pair_chk.sv
`timescale 1ns/1ps
module gear_div_pair_chk #(
  parameter int DIV_W = 4
) (
  input logic             core_clk,
  input logic             core_rst_n,
  input logic             mem_clk,
  input logic             mem_rst_n,
  input logic             cfg_valid_i,
  input logic             cfg_ready_o,
  input logic [DIV_W-1:0] cfg_m_i,
  input logic [DIV_W-1:0] cfg_n_i,
  input logic             cfg_ok_o,
  input logic             core_div_o,
  input logic             mem_div_o,
  input logic             core_run,
  input logic             mem_run
);
  logic take;
  assign take = cfg_valid_i && cfg_ready_o;

  a_r9_ready_drops: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    take |=> !cfg_ready_o);

  a_r2_zero_rejected: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (take && (cfg_m_i == '0 || cfg_n_i == '0)) |=> !cfg_ok_o);

  a_r10_ok_holds: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !take |=> $stable(cfg_ok_o));

  a_r7_core_stays_low: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (!core_run && !core_div_o) |=> !core_div_o);

  a_r7_mem_stays_low: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
    (!mem_run && !mem_div_o) |=> !mem_div_o);

  a_r5_core_rise_needs_run: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    $rose(core_div_o) |-> $past(core_run));

  a_r6_mem_rise_needs_run: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
    $rose(mem_div_o) |-> $past(mem_run));
endmodule

bind gear_div_pair gear_div_pair_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/gear_div_pair_bench.sv
`timescale 1ns/1ps
module gear_div_pair_bench;
  localparam realtime CORE_PERIOD_NS = 7.5;
  localparam realtime MEM_PERIOD_NS  = 10.0;
  localparam int DIV_W = 4;

  logic core_clk = 0, mem_clk = 0;
  logic core_rst_n = 0, mem_rst_n = 0;
  logic cfg_valid_i = 0, cfg_en_i = 0;
  logic [DIV_W-1:0] cfg_m_i = '0, cfg_n_i = '0;
  logic cfg_ready_o, cfg_ok_o, core_div_o, mem_div_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CORE_PERIOD_NS/2) core_clk = ~core_clk;
  always #(MEM_PERIOD_NS/2)  mem_clk  = ~mem_clk;

  gear_div_pair u_gear_div_pair (.*);

  typedef struct packed {
    logic [3:0] m, n;
    logic       en, ok;
    logic [7:0] chi, cper, mhi, mper;
  } vec_t;

  // cper/mper = 0 means the output is expected to stay low
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd4,  4'd3,  1'b1, 1'b1, 8'd2, 8'd4,  8'd1, 8'd3},
    '{4'd8,  4'd6,  1'b1, 1'b1, 8'd4, 8'd8,  8'd3, 8'd6},
    '{4'd4,  4'd4,  1'b1, 1'b1, 8'd2, 8'd4,  8'd2, 8'd4},
    '{4'd6,  4'd4,  1'b1, 1'b1, 8'd3, 8'd6,  8'd2, 8'd4},
    '{4'd8,  4'd4,  1'b1, 1'b1, 8'd4, 8'd8,  8'd2, 8'd4},
    '{4'd12, 4'd9,  1'b1, 1'b1, 8'd6, 8'd12, 8'd4, 8'd9},
    '{4'd9,  4'd6,  1'b1, 1'b1, 8'd4, 8'd9,  8'd3, 8'd6},
    '{4'd5,  4'd3,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0, 8'd0},
    '{4'd2,  4'd2,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0, 8'd0},
    '{4'd0,  4'd3,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0, 8'd0},
    '{4'd4,  4'd0,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0, 8'd0},
    '{4'd4,  4'd3,  1'b0, 1'b1, 8'd0, 8'd0,  8'd0, 8'd0},
    '{4'd13, 4'd10, 1'b1, 1'b0, 8'd0, 8'd0,  8'd0, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit mem_side);
    if (mem_side) @(negedge mem_clk);
    else          @(negedge core_clk);
  endtask

  function automatic logic sample(input bit mem_side);
    return mem_side ? mem_div_o : core_div_o;
  endfunction

  // Measure one period from a rising edge: high count and total length
  task automatic measure(input bit mem_side, output int hi, output int per);
    int guard = 0;
    hi = 0; per = 0;
    while (sample(mem_side) !== 1'b0 && guard < 200) begin tick(mem_side); guard++; end
    while (sample(mem_side) !== 1'b1 && guard < 200) begin tick(mem_side); guard++; end
    if (guard >= 200) return;
    while (sample(mem_side) === 1'b1 && guard < 400) begin hi++; per++; tick(mem_side); guard++; end
    while (sample(mem_side) === 1'b0 && guard < 400) begin per++; tick(mem_side); guard++; end
  endtask

  task automatic count_high(input bit mem_side, input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      tick(mem_side);
      if (sample(mem_side) !== 1'b0) highs++;
    end
  endtask

  task automatic wait_ready();
    int guard = 0;
    @(negedge core_clk);
    while (cfg_ready_o !== 1'b1 && guard < 100) begin @(negedge core_clk); guard++; end
  endtask

  task automatic apply(input logic [3:0] m, input logic [3:0] n, input logic en);
    wait_ready();
    cfg_valid_i = 1; cfg_m_i = m; cfg_n_i = n; cfg_en_i = en;
    @(negedge core_clk);
    cfg_valid_i = 0;
  endtask

  // Length check on every high pulse of the core output
  bit mon_on = 0;
  int allow_a = 0, allow_b = 0, hi_run = 0, bad_runs = 0;
  always @(negedge core_clk) begin
    if (core_div_o === 1'b1) hi_run++;
    else begin
      if (mon_on && hi_run != 0 && hi_run != allow_a && hi_run != allow_b) bad_runs++;
      hi_run = 0;
    end
  end

  initial begin
    #(CORE_PERIOD_NS * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, per, highs;
    // R1: reset state
    repeat (3) @(negedge core_clk);
    check("R1 core low in reset", int'(core_div_o), 0);
    check("R1 mem low in reset", int'(mem_div_o), 0);
    core_rst_n = 1; mem_rst_n = 1;
    repeat (2) @(negedge core_clk);
    check("R1 ready after reset", int'(cfg_ready_o), 1);
    check("R1 ok low after reset", int'(cfg_ok_o), 0);
    count_high(0, 20, highs); check("R1 core idle", highs, 0);
    count_high(1, 20, highs); check("R1 mem idle", highs, 0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v].m, VEC[v].n, VEC[v].en);
      wait_ready();
      check($sformatf("R2/R3/R4 ok row %0d", v), int'(cfg_ok_o), int'(VEC[v].ok));
      repeat (40) @(negedge mem_clk);
      if (VEC[v].cper != 0) begin
        measure(0, hi, per);
        check($sformatf("R5 core high row %0d", v), hi, int'(VEC[v].chi));
        check($sformatf("R5 core period row %0d", v), per, int'(VEC[v].cper));
        measure(1, hi, per);
        check($sformatf("R6 mem high row %0d", v), hi, int'(VEC[v].mhi));
        check($sformatf("R6 mem period row %0d", v), per, int'(VEC[v].mper));
      end else begin
        count_high(0, 60, highs); check($sformatf("R7 core low row %0d", v), highs, 0);
        count_high(1, 60, highs); check($sformatf("R7 mem low row %0d", v), highs, 0);
      end
    end

    // R8: switch divisors while running, then disable while running
    apply(4'd4, 4'd3, 1'b1);
    repeat (30) @(negedge mem_clk);
    allow_a = 2; allow_b = 4; mon_on = 1;
    apply(4'd8, 4'd6, 1'b1);
    repeat (30) @(negedge mem_clk);
    measure(0, hi, per);
    check("R8 core period after switch", per, 8);
    measure(1, hi, per);
    check("R8 mem period after switch", per, 6);
    allow_a = 4; allow_b = 4;
    apply(4'd8, 4'd6, 1'b0);
    repeat (30) @(negedge mem_clk);
    mon_on = 0;
    check("R8 no runt high pulse", bad_runs, 0);
    count_high(0, 40, highs); check("R7 core low after disable", highs, 0);

    // R9 R10: offer during crossing is not taken
    apply(4'd4, 4'd3, 1'b1);
    check("R9 ready low after transfer", int'(cfg_ready_o), 0);
    cfg_valid_i = 1; cfg_m_i = 4'd0; cfg_n_i = 4'd0; cfg_en_i = 1'b1;
    @(negedge core_clk);
    cfg_valid_i = 0;
    wait_ready();
    check("R10 ok unchanged by ignored offer", int'(cfg_ok_o), 1);
    repeat (30) @(negedge mem_clk);
    measure(0, hi, per);
    check("R9 core period kept", per, 4);
    measure(1, hi, per);
    check("R9 mem period kept", per, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule